// File: doc/BRIEF.md
# Leading-One Normalize and Truncate Unit

This block sits at the back end of a floating-point datapath. It receives a double-width raw mantissa (48 bits by default), a sign and a signed, biased exponent from an integer multiply or add stage. It returns one packed single-precision word. The exponent is taken to describe a value whose binary point lies just below bit 46 of the raw mantissa. That is the layout of a product of two 24-bit significands.

A priority encoder finds the most significant set bit of the mantissa. That single position then drives two things: a left barrel shift that moves the leading one up to the top bit, and the exponent correction. The upper half of the shifted mantissa is kept. The leading one in it becomes the implicit bit, and the remaining 23 bits form the fraction field. The lower half of the mantissa is discarded with no rounding. Results that fall outside the exponent range raise a flag and are replaced by a fixed pattern.

Inputs are taken when `in_valid` is high, and the result appears registered one cycle later.

Top module: `fp_norm_trunc`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. After reset, `out_valid`, `out_ovf`, `out_unf` and `out_word` are all zero.
- R2: For a nonzero mantissa whose highest set bit is at position p, the fraction field `out_word[22:0]` holds the 23 mantissa bits directly below p, most significant first. Positions below bit 0 count as zero.
- R3: For a nonzero mantissa whose highest set bit is at position p, the exponent field `out_word[30:23]` equals `in_exp + 1 - (47 - p)`, when that value lies between 1 and 254.
- R4: Mantissa bits more than 23 places below the leading one have no effect on the output.
- R5: `out_word[31]` equals `in_sign` for every input, including zero, overflow and underflow results.
- R6: When the adjusted exponent exceeds 254, `out_ovf` is 1, `out_unf` is 0, and the word is the sign followed by exponent 254 and an all-ones fraction.
- R7: When the adjusted exponent is below 1, `out_unf` is 1, `out_ovf` is 0, and `out_word[30:0]` is zero.
- R8: An all-zero mantissa gives `out_word[30:0]` equal to zero with both flags low, whatever the exponent.
- R9: While `in_valid` is low, `out_word`, `out_ovf` and `out_unf` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 10 | Signed biased exponent, binary point below mantissa bit 46 |
| in_mant | input | 48 | Raw double-width mantissa |
| out_valid | output | 1 | Registered result is valid |
| out_word | output | 32 | Packed result: sign, 8-bit exponent, 23-bit fraction |
| out_ovf | output | 1 | Exponent above range; word saturated |
| out_unf | output | 1 | Exponent below range; word forced to zero |

## Verification
The main sweep uses a narrow instance: a 10-bit mantissa, 4-bit exponent field and 4-bit fraction. Every mantissa value is combined with every signed input exponent, so each leading-one position meets each range boundary. This exposes an off-by-one in the position-to-exponent formula, which would shift every exponent by one. It also exposes a shifter that drops or duplicates a bit at small positions, which would corrupt fractions for short mantissas. A priority encoder that picks the lowest set bit instead of the highest would corrupt almost every word.

The exponent values 0, 1, 254 and 255 (and their narrow equivalents) sit on the range edges. A comparison written with the wrong strictness flags a legal result or passes an illegal one there. All-zero mantissas with large exponents catch a design that raises overflow for zero. Idle cycles catch outputs that change without a valid input. A full-width instance then repeats the edges and the truncation case at the default widths.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  // Classification of a normalized result before packing.
  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_ZERO   = 2'd1,
    CLS_OVER   = 2'd2,
    CLS_UNDER  = 2'd3
  } res_cls_e;
endpackage

// File: rtl/fpn_lead_one.sv
module fpn_lead_one #(
  parameter int W  = 48,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] lead_pos,
  output logic          lead_none
);
  // Priority encoder: the highest set bit wins because it is visited last.
  always_comb begin
    lead_pos  = '0;
    lead_none = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        lead_pos  = CW'(i);
        lead_none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpn_shift_left.sv
module fpn_shift_left #(
  parameter int W  = 48,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  // One stage per bit of the shift amount; stage s shifts by 2**s.
  logic [SW:0][W-1:0] stage;
  assign stage[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/fpn_exp_adjust.sv
module fpn_exp_adjust
  import fpn_pkg::*;
#(
  parameter int EXPIN_W = 10,
  parameter int EXP_W   = 8,
  parameter int CW      = 6
) (
  input  logic signed [EXPIN_W-1:0] exp_in,
  input  logic [CW-1:0]             lead_zeros,
  input  logic                      mant_zero,
  output res_cls_e                  cls,
  output logic [EXP_W-1:0]          exp_field
);
  localparam int SUM_W = EXPIN_W + CW + 2;
  localparam int MAXB  = (1 << EXP_W) - 2;

  // Adjusted exponent: the raw exponent assumes the leading one at bit W-2,
  // so a leading one at W-1 adds one and each leading zero removes one.
  function automatic logic [SUM_W-1:0] adj_exp(input logic [EXPIN_W-1:0] e,
                                               input logic [CW-1:0] lz);
    logic [SUM_W-1:0] ext;
    ext = {{(SUM_W-EXPIN_W){e[EXPIN_W-1]}}, e};
    return ext + SUM_W'(1) - {{(SUM_W-CW){1'b0}}, lz};
  endfunction

  logic [SUM_W-1:0] e_sum;
  logic             e_low, e_high;

  assign e_sum  = adj_exp(exp_in, lead_zeros);
  assign e_low  = e_sum[SUM_W-1] || (e_sum == '0);
  assign e_high = !e_sum[SUM_W-1] && (e_sum > SUM_W'(MAXB));

  always_comb begin
    if (mant_zero)   cls = CLS_ZERO;
    else if (e_high) cls = CLS_OVER;
    else if (e_low)  cls = CLS_UNDER;
    else             cls = CLS_NORMAL;
  end

  assign exp_field = e_sum[EXP_W-1:0];
endmodule

// File: rtl/fp_norm_trunc.sv
module fp_norm_trunc
  import fpn_pkg::*;
#(
  parameter int MANT_W  = 48,
  parameter int FRAC_W  = 23,
  parameter int EXP_W   = 8,
  parameter int EXPIN_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sign,
  input  logic signed [EXPIN_W-1:0]   in_exp,
  input  logic [MANT_W-1:0]           in_mant,
  output logic                        out_valid,
  output logic [EXP_W+FRAC_W:0]       out_word,
  output logic                        out_ovf,
  output logic                        out_unf
);
  localparam int CW    = $clog2(MANT_W);
  localparam int KEEP  = FRAC_W + 1;
  localparam int OUT_W = 1 + EXP_W + FRAC_W;
  localparam int MAXB  = (1 << EXP_W) - 2;

  // Named internal events for the assertions.
  logic [CW-1:0]     lead_pos;
  logic              lead_none;
  logic [CW-1:0]     lead_zeros;
  logic [MANT_W-1:0] mant_norm;
  logic [KEEP-1:0]   mant_kept;
  logic [FRAC_W-1:0] frac_field;
  logic [EXP_W-1:0]  exp_field;
  res_cls_e          cls;
  logic [OUT_W-1:0]  word_next;

  fpn_lead_one #(.W(MANT_W), .CW(CW)) u_lod (
    .vec       (in_mant),
    .lead_pos  (lead_pos),
    .lead_none (lead_none)
  );

  assign lead_zeros = CW'(MANT_W - 1) - lead_pos;

  fpn_shift_left #(.W(MANT_W), .SW(CW)) u_shift (
    .din  (in_mant),
    .amt  (lead_zeros),
    .dout (mant_norm)
  );

  // Truncation: only the top KEEP bits survive; the hidden bit is dropped.
  assign mant_kept  = mant_norm[MANT_W-1 -: KEEP];
  assign frac_field = mant_kept[FRAC_W-1:0];

  fpn_exp_adjust #(.EXPIN_W(EXPIN_W), .EXP_W(EXP_W), .CW(CW)) u_exp (
    .exp_in     (in_exp),
    .lead_zeros (lead_zeros),
    .mant_zero  (lead_none),
    .cls        (cls),
    .exp_field  (exp_field)
  );

  function automatic logic [OUT_W-1:0] pack(input logic s, input res_cls_e c,
                                            input logic [EXP_W-1:0] e,
                                            input logic [FRAC_W-1:0] f);
    case (c)
      CLS_NORMAL: return {s, e, f};
      CLS_OVER:   return {s, EXP_W'(MAXB), {FRAC_W{1'b1}}};
      default:    return {s, {(OUT_W-1){1'b0}}};
    endcase
  endfunction

  assign word_next = pack(in_sign, cls, exp_field, frac_field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= word_next;
        out_ovf  <= (cls == CLS_OVER);
        out_unf  <= (cls == CLS_UNDER);
      end
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_leading_one_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lead_none) |-> mant_norm[MANT_W-1]);
  assert_sign_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word[OUT_W-1] == $past(in_sign)));
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ovf && out_unf));
  assert_no_all_ones_exp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[OUT_W-2 -: EXP_W] != {EXP_W{1'b1}}));
  assert_underflow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_unf |-> (out_word[OUT_W-2:0] == '0));
  assert_zero_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lead_none) |=> (!out_ovf && !out_unf));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_word) && $stable(out_ovf) && $stable(out_unf)));
endmodule

// File: tb/test_fp_norm_trunc.sv
module test_fp_norm_trunc;
  // Narrow configuration for the exhaustive sweep.
  localparam int SM = 10, SF = 4, SE = 4, SX = 6;
  // Default configuration for directed edges.
  localparam int BM = 48, BF = 23, BE = 8, BX = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_cmp = 0;
  int n_bad = 0;

  // Narrow instance signals.
  logic s_iv = 0, s_is = 0;
  logic signed [SX-1:0] s_ie = '0;
  logic [SM-1:0] s_im = '0;
  logic s_ov_valid, s_ovf, s_unf;
  logic [SE+SF:0] s_w;

  // Full-width instance signals.
  logic i_iv = 0, i_is = 0;
  logic signed [BX-1:0] i_ie = '0;
  logic [BM-1:0] i_im = '0;
  logic b_ov_valid, b_ovf, b_unf;
  logic [BE+BF:0] b_w;

  fp_norm_trunc #(.MANT_W(SM), .FRAC_W(SF), .EXP_W(SE), .EXPIN_W(SX)) i_fp_norm_trunc_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_sign(s_is), .in_exp(s_ie),
    .in_mant(s_im), .out_valid(s_ov_valid), .out_word(s_w), .out_ovf(s_ovf), .out_unf(s_unf));

  fp_norm_trunc i_fp_norm_trunc (
    .clk(clk), .rst_n(rst_n), .in_valid(i_iv), .in_sign(i_is), .in_exp(i_ie),
    .in_mant(i_im), .out_valid(b_ov_valid), .out_word(b_w), .out_ovf(b_ovf), .out_unf(b_unf));

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // Reference model written from the requirements.
  function automatic void model(input int M, input int F, input int E,
                                input longint unsigned mant, input longint ex, input bit sg,
                                output longint unsigned w, output bit ov, output bit un);
    int p = -1;
    longint e, maxb;
    longint unsigned fmask, frac, shi;
    for (int i = M - 1; i >= 0; i--) if (p < 0 && mant[i]) p = i;
    shi = longint'(sg) << (E + F);
    ov = 0; un = 0;
    fmask = (64'd1 << F) - 1;
    maxb = (longint'(1) << E) - 2;
    if (p < 0) begin
      w = shi;
    end else begin
      e = ex + 1 - (M - 1 - p);
      if (e > maxb) begin
        ov = 1; w = shi | (longint'(maxb) << F) | fmask;
      end else if (e < 1) begin
        un = 1; w = shi;
      end else begin
        frac = (p >= F) ? (mant >> (p - F)) : (mant << (F - p));
        w = shi | (longint'(e) << F) | (frac & fmask);
      end
    end
  endfunction

  // Pending expectations (one cycle of latency).
  bit s_pend = 0; bit s_pend_v = 0; longint unsigned s_xw = 0; bit s_xo = 0, s_xu = 0;
  string s_tag = "";
  bit b_pend = 0; bit b_pend_v = 0; longint unsigned b_xw = 0; bit b_xo = 0, b_xu = 0;
  string b_tag = "";

  task automatic check_s();
    if (!s_pend) return;
    if (s_pend_v) begin
      chk("R1 small valid", longint'(s_ov_valid), 1);
      chk(s_tag, longint'(s_w), s_xw);
      chk("R5 small sign", longint'(s_w[SE+SF]), s_xw >> (SE + SF));
      chk("R6 small ovf", longint'(s_ovf), longint'(s_xo));
      chk("R7 small unf", longint'(s_unf), longint'(s_xu));
    end else begin
      chk("R1 small idle valid", longint'(s_ov_valid), 0);
      chk("R9 small hold word", longint'(s_w), s_xw);
      chk("R9 small hold flags", longint'({s_ovf, s_unf}), longint'({s_xo, s_xu}));
    end
  endtask

  task automatic step_s(input bit v, input bit sg, input longint ex, input longint unsigned m);
    longint unsigned w; bit ov, un;
    @(negedge clk);
    check_s();
    s_iv = v; s_is = sg; s_ie = SX'(ex); s_im = SM'(m);
    s_pend = 1; s_pend_v = v;
    if (v) begin
      model(SM, SF, SE, m, ex, sg, w, ov, un);
      s_xw = w; s_xo = ov; s_xu = un;
      s_tag = (m == 0) ? "R8 small zero" : ov ? "R6 small word" : un ? "R7 small word"
            : "R2/R3 small word";
    end
  endtask

  task automatic check_b();
    if (!b_pend) return;
    if (b_pend_v) begin
      chk("R1 wide valid", longint'(b_ov_valid), 1);
      chk(b_tag, longint'(b_w), b_xw);
      chk("R5 wide sign", longint'(b_w[31]), b_xw >> 31);
      chk("R6 wide ovf", longint'(b_ovf), longint'(b_xo));
      chk("R7 wide unf", longint'(b_unf), longint'(b_xu));
    end else begin
      chk("R1 wide idle valid", longint'(b_ov_valid), 0);
      chk("R9 wide hold", longint'({b_ovf, b_unf, b_w}), longint'({b_xo, b_xu, 32'(b_xw)}));
    end
  endtask

  task automatic step_b(input bit v, input bit sg, input longint ex, input longint unsigned m,
                        input string tag);
    longint unsigned w; bit ov, un;
    @(negedge clk);
    check_b();
    i_iv = v; i_is = sg; i_ie = BX'(ex); i_im = BM'(m);
    b_pend = 1; b_pend_v = v;
    if (v) begin
      model(BM, BF, BE, m, ex, sg, w, ov, un);
      b_xw = w; b_xo = ov; b_xu = un; b_tag = tag;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state.
    chk("R1 reset small", longint'({s_ov_valid, s_ovf, s_unf, s_w}), 0);
    chk("R1 reset wide", longint'({b_ov_valid, b_ovf, b_unf, b_w}), 0);
    rst_n = 1'b1;

    // Exhaustive narrow sweep, with periodic idle cycles (R9).
    for (int ex = -(1 << (SX - 1)); ex < (1 << (SX - 1)); ex++) begin
      for (int m = 0; m < (1 << SM); m++) begin
        cnt++;
        if (cnt % 16 == 0) step_s(0, 1'b1, 5, 10'h3ff);
        step_s(1, bit'(m ^ ex), ex, longint'(m));
      end
    end
    step_s(0, 0, 0, 0);
    step_s(0, 0, 0, 0);

    // Directed full-width cases.
    step_b(1, 0, 100, 48'h8000_0000_0000, "R3 wide lead at top");
    step_b(1, 1, 100, 48'h4000_0000_0000, "R3 wide lead at 46");
    step_b(1, 0, 100, 48'h0000_0000_0001, "R3 wide lead at 0");
    step_b(1, 0, 50,  48'h5A5A_5A5A_5A5A, "R2 wide fraction");
    // R4: low bits below the kept window change nothing.
    step_b(1, 0, 50,  48'h4000_007F_FFFF, "R4 wide truncation");
    step_b(1, 0, 50,  48'h4000_0000_0000, "R4 wide truncation ref");
    step_b(0, 1, 7,   48'hFFFF_FFFF_FFFF, "R9");
    step_b(1, 1, 254, 48'h4000_0000_0000, "R3 wide exp 254");
    step_b(1, 0, 254, 48'h8000_0000_0000, "R6 wide overflow");
    step_b(1, 1, 511, 48'hC000_0000_0001, "R6 wide overflow large");
    step_b(1, 0, 1,   48'h4000_0000_0000, "R3 wide exp 1");
    step_b(1, 1, 0,   48'h4000_0000_0000, "R7 wide underflow at 0");
    step_b(1, 0, -300, 48'h8000_0000_0000, "R7 wide underflow negative");
    step_b(1, 1, 511, 48'h0,               "R8 wide zero mantissa");
    step_b(0, 0, 0, 0, "R9");
    step_b(0, 0, 0, 0, "R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule